// File: doc/BRIEF.md
# NAND Boot-Block Search Sequencer

This block hunts for a valid boot configuration record stored as several redundant copies on NAND flash. After a start pulse it requests raw reads of candidate pages, beginning at page 0 and moving forward by a fixed page stride. After each read an external checker returns two verdicts with a done strobe: whether the error-correction check passed and whether the record's fingerprint matched. The search ends at the first candidate that passes both checks, and the block reports that page. If no candidate passes, the block raises an error that sends the boot flow into recovery.

Two fuse-style inputs set the search. A 4-bit exponent chooses how many copies are tried (a power of two). A 4-bit multiplier chooses the spacing in units of 64 pages. A zero in either field is an unprogrammed fuse and selects a fixed default. Both fields are captured when the search starts. The flash bus protocol and the Hamming decode are outside this block and reach it only through the read request and done handshake.

Top module: `nand_boot_search`

## Requirements
- R1: While reset is active and afterwards until the first start, busy, found, error and rd_req are all low.
- R2: A start pulse while idle raises busy, clears found and error, and issues a read request for page 0. rd_req is high for exactly one cycle per candidate.
- R3: The number of candidates tried is 2 to the power of fuse_cnt_exp. A value of 0 selects 4 candidates. The range therefore runs from 2 (exponent 1) to 32768 (exponent 15).
- R4: Candidate k is requested at page k × 64 × M, where M is fuse_stride. An M of 0 is treated as 1, and an M of 15 gives a spacing of 960 pages.
- R5: A candidate is valid only if rd_done arrives with both ecc_ok and fp_ok high. A failure of either check moves the search to the next candidate.
- R6: On a valid candidate the block drops busy, raises found, places the candidate's page on found_page, and issues no further reads.
- R7: When every candidate has failed, the block drops busy, raises error, and issues no further reads.
- R8: found and error are never high together. Each stays high until the next accepted start.
- R9: A start pulse while busy is ignored. The current search goes on with the same page sequence.
- R10: The fuse inputs are captured at the accepted start. Changing them during a search does not change the pages requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search (acted on only when idle) |
| fuse_cnt_exp | input | 4 | Exponent for the candidate count; 0 selects 4 candidates |
| fuse_stride | input | 4 | Spacing multiplier in units of 64 pages; 0 is treated as 1 |
| rd_req | output | 1 | One-cycle request for a raw page read |
| rd_page | output | 25 | Page address of the requested read |
| rd_done | input | 1 | Checker verdict strobe for the outstanding read |
| ecc_ok | input | 1 | ECC check passed (valid with rd_done) |
| fp_ok | input | 1 | Fingerprint matched (valid with rd_done) |
| busy | output | 1 | Search in progress |
| found | output | 1 | Valid copy located; held until next start |
| found_page | output | 25 | Page of the valid copy |
| error | output | 1 | All candidates failed; held until next start |

## Verification
The hardest cases to reach are the end of a long search: a hit on the very last candidate, and the final failure after the whole count has been used. Both require the bench to answer every earlier read with a failing verdict. Each scenario task therefore acts as the read responder. It answers every request in turn, alternating between ECC failures and fingerprint failures, until it reaches the chosen hit index or the full candidate count. Along the way, one run injects a start pulse and a fuse change mid-search to show that neither alters the page sequence.

// File: rtl/nbs_pkg.sv
package nbs_pkg;
  typedef enum logic [1:0] {
    NBS_IDLE  = 2'd0,
    NBS_ISSUE = 2'd1,
    NBS_WAIT  = 2'd2
  } nbs_state_e;
endpackage

// File: rtl/nbs_rst_sync.sv
module nbs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/nbs_fuse_decode.sv
module nbs_fuse_decode #(
  parameter int FUSE_W      = 4,
  parameter int PAGE_W      = 25,
  parameter int STRIDE_UNIT = 64,
  parameter int DEFAULT_EXP = 2,
  localparam int IDX_W      = 2 ** FUSE_W
) (
  input  logic [FUSE_W-1:0] cnt_exp,
  input  logic [FUSE_W-1:0] stride_mult,
  output logic [IDX_W-1:0]  last_idx,
  output logic [PAGE_W-1:0] step
);
  logic [FUSE_W-1:0] eff_exp;
  logic [FUSE_W-1:0] eff_mult;

  always_comb begin
    eff_exp  = (cnt_exp == '0) ? FUSE_W'(DEFAULT_EXP) : cnt_exp;
    eff_mult = (stride_mult == '0) ? FUSE_W'(1) : stride_mult;
    last_idx = (IDX_W'(1) << eff_exp) - IDX_W'(1);
    step     = PAGE_W'(eff_mult) * PAGE_W'(STRIDE_UNIT);
  end
endmodule

// File: rtl/nbs_cursor.sv
module nbs_cursor #(
  parameter int PAGE_W = 25,
  parameter int IDX_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  input  logic [PAGE_W-1:0] step,
  input  logic [IDX_W-1:0]  last_idx,
  output logic [PAGE_W-1:0] page,
  output logic              at_last
);
  logic [PAGE_W-1:0] page_q, page_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              en;

  always_comb begin
    en     = clr | adv;
    page_d = clr ? '0 : page_q + step;
    idx_d  = clr ? '0 : idx_q + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      idx_q  <= '0;
    end else if (en) begin
      page_q <= page_d;
      idx_q  <= idx_d;
    end
  end

  assign page    = page_q;
  assign at_last = (idx_q == last_idx);
endmodule

// File: rtl/nand_boot_search.sv
module nand_boot_search #(
  parameter int FUSE_W      = 4,
  parameter int PAGE_W      = 25,
  parameter int STRIDE_UNIT = 64,
  parameter int DEFAULT_EXP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [FUSE_W-1:0] fuse_cnt_exp,
  input  logic [FUSE_W-1:0] fuse_stride,
  output logic              rd_req,
  output logic [PAGE_W-1:0] rd_page,
  input  logic              rd_done,
  input  logic              ecc_ok,
  input  logic              fp_ok,
  output logic              busy,
  output logic              found,
  output logic [PAGE_W-1:0] found_page,
  output logic              error
);
  import nbs_pkg::*;

  localparam int IDX_W = 2 ** FUSE_W;

  logic rst_n_i;
  nbs_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i));

  nbs_state_e        state_q, state_d;
  logic [FUSE_W-1:0] exp_q, mult_q;
  logic              found_q, found_d, error_q, error_d;
  logic [PAGE_W-1:0] fpage_q, fpage_d;
  logic              accept, verdict, pass, clr, adv, res_en;
  logic [IDX_W-1:0]  last_idx;
  logic [PAGE_W-1:0] step, page;
  logic              at_last;

  nbs_fuse_decode #(
    .FUSE_W(FUSE_W), .PAGE_W(PAGE_W),
    .STRIDE_UNIT(STRIDE_UNIT), .DEFAULT_EXP(DEFAULT_EXP)
  ) u_dec (
    .cnt_exp(exp_q), .stride_mult(mult_q), .last_idx(last_idx), .step(step)
  );

  nbs_cursor #(.PAGE_W(PAGE_W), .IDX_W(IDX_W)) u_cur (
    .clk(clk), .rst_n(rst_n_i), .clr(clr), .adv(adv),
    .step(step), .last_idx(last_idx), .page(page), .at_last(at_last)
  );

  // next-state logic
  always_comb begin
    accept  = (state_q == NBS_IDLE) && start;
    verdict = (state_q == NBS_WAIT) && rd_done;
    pass    = ecc_ok && fp_ok;
    clr     = accept;
    adv     = verdict && !pass && !at_last;
    state_d = state_q;
    found_d = found_q;
    error_d = error_q;
    fpage_d = fpage_q;
    res_en  = 1'b0;
    unique case (state_q)
      NBS_IDLE: if (accept) begin
        state_d = NBS_ISSUE;
        found_d = 1'b0;
        error_d = 1'b0;
        res_en  = 1'b1;
      end
      NBS_ISSUE: state_d = NBS_WAIT;
      NBS_WAIT: if (verdict) begin
        if (pass) begin
          state_d = NBS_IDLE;
          found_d = 1'b1;
          fpage_d = page;
          res_en  = 1'b1;
        end else if (at_last) begin
          state_d = NBS_IDLE;
          error_d = 1'b1;
          res_en  = 1'b1;
        end else begin
          state_d = NBS_ISSUE;
        end
      end
      default: state_d = NBS_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= NBS_IDLE;
      exp_q   <= '0;
      mult_q  <= '0;
      found_q <= 1'b0;
      error_q <= 1'b0;
      fpage_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        exp_q  <= fuse_cnt_exp;
        mult_q <= fuse_stride;
      end
      if (res_en) begin
        found_q <= found_d;
        error_q <= error_d;
        fpage_q <= fpage_d;
      end
    end
  end

  assign rd_req     = (state_q == NBS_ISSUE);
  assign rd_page    = page;
  assign busy       = (state_q != NBS_IDLE);
  assign found      = found_q;
  assign found_page = fpage_q;
  assign error      = error_q;
endmodule

// File: rtl/nbs_checker.sv
module nbs_checker (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic rd_req,
  input logic rd_done,
  input logic ecc_ok,
  input logic fp_ok,
  input logic busy,
  input logic found,
  input logic error
);
  AST_RESULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(found && error)); // R8
  AST_FOUND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    found && !start |=> found); // R8
  AST_ERROR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    error && !start |=> error); // R8
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req); // R2
  AST_REQ_IN_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> busy); // R2
  AST_FOUND_NEEDS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(found) |-> $past(rd_done && ecc_ok && fp_ok) && !busy); // R5
  AST_ERROR_AFTER_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> $past(rd_done && !(ecc_ok && fp_ok)) && !busy); // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !rd_done |=> busy); // R9
endmodule

bind nand_boot_search nbs_checker u_nbs_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .rd_req(rd_req),
  .rd_done(rd_done), .ecc_ok(ecc_ok), .fp_ok(fp_ok),
  .busy(busy), .found(found), .error(error)
);

// File: tb/nand_boot_search_bench.sv
`timescale 1ns/1ps
module nand_boot_search_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [3:0]  fuse_cnt_exp, fuse_stride;
  logic        rd_req;
  logic [24:0] rd_page;
  logic        rd_done, ecc_ok, fp_ok;
  logic        busy, found, error;
  logic [24:0] found_page;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  nand_boot_search u_nand_boot_search (
    .clk(clk), .rst_n(rst_n), .start(start),
    .fuse_cnt_exp(fuse_cnt_exp), .fuse_stride(fuse_stride),
    .rd_req(rd_req), .rd_page(rd_page), .rd_done(rd_done),
    .ecc_ok(ecc_ok), .fp_ok(fp_ok), .busy(busy), .found(found),
    .found_page(found_page), .error(error)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 195000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles, expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One search: hit < 0 means every candidate fails.
  task automatic run_case(input logic [3:0] e, input logic [3:0] s,
                          input int hit, input bit disturb);
    int n    = (e == 0) ? 4 : (1 << e);
    int step = ((s == 0) ? 1 : int'(s)) * 64;
    int wait_n;
    bit extra;
    fuse_cnt_exp = e;
    fuse_stride  = s;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R2 busy after start", busy, 1);
    chk("R2 found cleared", found, 0);
    chk("R2 error cleared", error, 0);
    for (int k = 0; k < n; k++) begin
      wait_n = 0;
      while (!rd_req && wait_n < 20) begin
        @(negedge clk); wait_n++;
      end
      if (k == 0 || k == n - 1 || k == hit || rd_page !== 25'(k * step))
        chk("R3/R4 request page", rd_page, k * step);
      if (!rd_req) begin
        chk("R3 candidate requested", 0, 1);
        break;
      end
      if (disturb && k == 1) begin
        start = 1'b1;          // R9: ignored while busy
        fuse_stride = s ^ 4'h5; // R10: no effect mid-search
        fuse_cnt_exp = 4'd1;
      end
      @(negedge clk);
      start   = 1'b0;
      rd_done = 1'b1;
      ecc_ok  = (k == hit) || k[0];
      fp_ok   = (k == hit) || !k[0];  // R5: exactly one check fails otherwise
      @(negedge clk);
      rd_done = 1'b0;
      if (k == hit) break;
    end
    wait_n = 0;
    while (busy && wait_n < 20) begin
      @(negedge clk); wait_n++;
    end
    chk("R6/R7 busy dropped", busy, 0);
    if (hit >= 0) begin
      chk("R6 found", found, 1);
      chk("R6 found_page", found_page, hit * step);
      chk("R8 no error with found", error, 0);
    end else begin
      chk("R7 error", error, 1);
      chk("R8 no found with error", found, 0);
    end
    extra = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (rd_req) extra = 1'b1;
    end
    chk("R6/R7 no read after end", extra, 0);
    chk("R8 result held", found || error, 1);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; rd_done = 1'b0; ecc_ok = 1'b0; fp_ok = 1'b0;
    fuse_cnt_exp = '0; fuse_stride = '0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy, 0);
    chk("R1 found in reset", found, 0);
    chk("R1 error in reset", error, 0);
    chk("R1 rd_req in reset", rd_req, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle after reset", {busy, found, error, rd_req}, 0);

    run_case(4'd0,  4'd0,  0,  1'b0); // default fuses, first candidate
    run_case(4'd3,  4'd15, 0,  1'b0); // nondefault, first candidate
    run_case(4'd0,  4'd0,  3,  1'b0); // default, last of 4
    run_case(4'd3,  4'd15, 7,  1'b1); // last of 8, 960 spacing, R9/R10 disturb
    run_case(4'd0,  4'd0,  -1, 1'b0); // default, all fail
    run_case(4'd6,  4'd2,  -1, 1'b0); // 64 candidates all fail
    run_case(4'd1,  4'd1,  -1, 1'b0); // minimum count of 2
    run_case(4'd15, 4'd15, 5,  1'b1); // large count, early hit

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule